// File: doc/BRIEF.md
# Recursive Multiply-Accumulate Sequencer

This block runs one arithmetic operation per start strobe on signed two's-complement operands of width `DATA_W`. A pipelined multiplier forms a product, and a single-cycle adder/subtractor combines that product with either an external addend or the running sum. Two result registers are kept: the product register `m_o` and the sum register `z_o`. Both hold their values between operations, so a later opcode can use them as operands.

Straight opcodes use only the external operands `a_i`, `b_i` and `c_i`. Recursive opcodes feed back the product or sum left by the previous operation. The timing is fixed. `m_o` takes its new value `MUL_LAT` cycles after the start edge, and `z_o` takes its new value one cycle after that. While an operation runs, the issuer must hold `opcode_i`, `a_i`, `b_i` and `c_i` steady and keep `start_i` low.

Top module: `rmac_core`

## Requirements
- R1: While `rst_ni` is low, `m_o`, `z_o`, `busy_o` and `done_o` are all zero. Asserting reset in the middle of an operation abandons that operation.
- R2: Opcode 0 (3'b000) writes `m_o = a*b` and leaves `z_o` unchanged.
- R3: Opcode 1 (3'b001) writes `z_o = c + m'`, where `m'` is the product register before the operation. `m_o` is unchanged.
- R4: Opcode 2 (3'b010) writes `z_o = c - m'`. `m_o` is unchanged.
- R5: Opcode 3 (3'b011) writes `m_o = a*b`, then writes `z_o = z' + a*b`, where `z'` is the sum register before the operation.
- R6: Opcode 4 (3'b100) writes `m_o = a*b`, then writes `z_o = z' - a*b`.
- R7: Opcode 5 (3'b101) writes `m_o = m' * a` and leaves `z_o` unchanged.
- R8: Call the clock edge that samples start edge k. With `MUL_LAT`=5, `m_o` holds its old value after edges k through k+4 and may change only at edge k+5. `z_o` may change only at edge k+6.
- R9: `busy_o` is high from edge k until edge k+6. `done_o` is high for exactly the one cycle after edge k+6, while the new results are visible.
- R10: A start strobe that arrives while `busy_o` is high is ignored. The running operation keeps its timing and its results.
- R11: Opcodes 6 and 7 are reserved. A start strobe carrying one of them launches nothing: `busy_o` and `done_o` stay low, and `m_o` and `z_o` are unchanged.
- R12: All arithmetic wraps modulo 2^`DATA_W` with no saturation. This covers negative operands and results in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch strobe, sampled at a rising edge |
| opcode_i | input | 3 | Operation select, held while busy |
| a_i | input | DATA_W | Multiplier operand |
| b_i | input | DATA_W | Second multiplier operand |
| c_i | input | DATA_W | External addend/minuend for opcodes 1 and 2 |
| m_o | output | DATA_W | Product result register |
| z_o | output | DATA_W | Sum result register |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with `DATA_W`=8 and the default `MUL_LAT`=5. The narrow width makes wraparound easy to reach with small operands: negative differences, products past 255 and sums that cross zero all occur in a short opcode chain. That chain passes results from one operation to the next, which exercises both feedback paths. Keeping the default latency lets the bench check the hold and update cycles of R8 at the exact edges the requirement names.

// File: rtl/rmac_pkg.sv
package rmac_pkg;

  localparam int OPC_W = 3;

  localparam logic [OPC_W-1:0] OPC_MUL    = 3'd0;
  localparam logic [OPC_W-1:0] OPC_ADD_C  = 3'd1;
  localparam logic [OPC_W-1:0] OPC_SUB_C  = 3'd2;
  localparam logic [OPC_W-1:0] OPC_ACC    = 3'd3;
  localparam logic [OPC_W-1:0] OPC_DEC    = 3'd4;
  localparam logic [OPC_W-1:0] OPC_SCALE  = 3'd5;

  function automatic logic opc_legal(input logic [OPC_W-1:0] op);
    return op <= OPC_SCALE;
  endfunction

  function automatic logic opc_wr_m(input logic [OPC_W-1:0] op);
    return op == OPC_MUL || op == OPC_ACC || op == OPC_DEC || op == OPC_SCALE;
  endfunction

  function automatic logic opc_wr_z(input logic [OPC_W-1:0] op);
    return op == OPC_ADD_C || op == OPC_SUB_C || op == OPC_ACC || op == OPC_DEC;
  endfunction

  function automatic logic opc_sub(input logic [OPC_W-1:0] op);
    return op == OPC_SUB_C || op == OPC_DEC;
  endfunction

  function automatic logic opc_use_c(input logic [OPC_W-1:0] op);
    return op == OPC_ADD_C || op == OPC_SUB_C;
  endfunction

  function automatic logic opc_m_fb(input logic [OPC_W-1:0] op);
    return op == OPC_SCALE;
  endfunction

endpackage

// File: rtl/rmac_seq.sv
module rmac_seq
  import rmac_pkg::*;
#(
  parameter int MUL_LAT = 5,
  localparam int LAST  = MUL_LAT + 1,
  localparam int CNT_W = $clog2(LAST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic             launch_o,
  output logic             busy_o,
  output logic             done_o,
  output logic [OPC_W-1:0] op_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             m_we_o,
  output logic             z_we_o
);

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OPC_W-1:0] op_q;
  logic             at_mul, at_last;

  assign launch_o = !busy_q && start_i && opc_legal(opcode_i);
  assign at_mul   = busy_q && (cnt_q == CNT_W'(MUL_LAT));
  assign at_last  = busy_q && (cnt_q == CNT_W'(LAST));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      op_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (launch_o) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(1);
        op_q   <= opcode_i;
      end else if (at_last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
        done_q <= 1'b1;
      end else if (busy_q) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign op_o   = op_q;
  assign cnt_o  = cnt_q;
  assign m_we_o = at_mul && opc_wr_m(op_q);
  assign z_we_o = at_last && opc_wr_z(op_q);

  a_r9_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && $past(busy_o));

  a_r10_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && cnt_o != CNT_W'(LAST) |=> busy_o && cnt_o == $past(cnt_o) + CNT_W'(1));

  a_r11_reserved_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && !opc_legal(opcode_i) |=> !busy_o);

endmodule

// File: rtl/rmac_mulpipe.sv
module rmac_mulpipe #(
  parameter int DATA_W = 16,
  parameter int LAT    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] prod_o,
  output logic              vld_o
);

  // stage 0 captures operands; stages 1..LAT-1 carry the product
  logic [DATA_W-1:0] a0_q, b0_q;
  logic              v0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a0_q <= '0;
      b0_q <= '0;
      v0_q <= 1'b0;
    end else begin
      v0_q <= launch_i;
      if (launch_i) begin
        a0_q <= opa_i;
        b0_q <= opb_i;
      end
    end
  end

  for (genvar g = 1; g < LAT; g++) begin : g_stg
    logic [DATA_W-1:0] p_d, p_q;
    logic              v_d, v_q;
    if (g == 1) begin : g_head
      assign p_d = a0_q * b0_q;
      assign v_d = v0_q;
    end else begin : g_tail
      assign p_d = g_stg[g-1].p_q;
      assign v_d = g_stg[g-1].v_q;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        p_q <= '0;
        v_q <= 1'b0;
      end else begin
        v_q <= v_d;
        if (v_d) p_q <= p_d;
      end
    end
  end

  assign prod_o = g_stg[LAT-1].p_q;
  assign vld_o  = g_stg[LAT-1].v_q;

endmodule

// File: rtl/rmac_addsub.sv
module rmac_addsub #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  input  logic              sub_i,
  output logic [DATA_W-1:0] s_o
);

  logic [DATA_W-1:0] y_eff;

  // x + (~y) + 1 for subtraction, wraps at DATA_W
  assign y_eff = sub_i ? ~y_i : y_i;
  assign s_o   = x_i + y_eff + DATA_W'(sub_i);

endmodule

// File: rtl/rmac_core.sv
module rmac_core
  import rmac_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int MUL_LAT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        opcode_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  output logic [DATA_W-1:0] m_o,
  output logic [DATA_W-1:0] z_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int LAST  = MUL_LAT + 1;
  localparam int CNT_W = $clog2(LAST + 1);

  logic             launch, m_we, z_we, pipe_vld;
  logic [OPC_W-1:0] op_run;
  logic [CNT_W-1:0] seq_cnt;
  logic [DATA_W-1:0] mul_a, mul_b, prod, add_x, sum;
  logic [DATA_W-1:0] m_q, z_q;

  rmac_seq #(.MUL_LAT(MUL_LAT)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .opcode_i (opcode_i),
    .launch_o (launch),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .op_o     (op_run),
    .cnt_o    (seq_cnt),
    .m_we_o   (m_we),
    .z_we_o   (z_we)
  );

  // recursive scale multiplies the held product by a
  assign mul_a = opc_m_fb(opcode_i) ? m_q : a_i;
  assign mul_b = opc_m_fb(opcode_i) ? a_i : b_i;

  rmac_mulpipe #(.DATA_W(DATA_W), .LAT(MUL_LAT)) u_mul (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .opa_i    (mul_a),
    .opb_i    (mul_b),
    .prod_o   (prod),
    .vld_o    (pipe_vld)
  );

  // sum stage reads the product register, already updated for acc/dec
  assign add_x = opc_use_c(op_run) ? c_i : z_q;

  rmac_addsub #(.DATA_W(DATA_W)) u_add (
    .x_i   (add_x),
    .y_i   (m_q),
    .sub_i (opc_sub(op_run)),
    .s_o   (sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0;
      z_q <= '0;
    end else begin
      if (m_we) m_q <= prod;
      if (z_we) z_q <= sum;
    end
  end

  assign m_o = m_q;
  assign z_o = z_q;

  a_r8_m_hold_early: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && seq_cnt < CNT_W'(MUL_LAT) |=> $stable(m_o));

  a_r8_z_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(z_o));

  a_r2_product_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_we |-> pipe_vld);

  a_r9_busy_until_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

endmodule

// File: tb/sim_rmac_core.sv
module sim_rmac_core;
  localparam int W   = 8;
  localparam int LAT = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [2:0]   opcode;
  logic [W-1:0] a, b, c;
  logic [W-1:0] m_o, z_o;
  logic         busy, done;

  always #10 clk = ~clk;

  rmac_core #(.DATA_W(W), .MUL_LAT(LAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .a_i(a), .b_i(b), .c_i(c), .m_o(m_o), .z_o(z_o),
    .busy_o(busy), .done_o(done)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  typedef struct packed { logic [W-1:0] m; logic [W-1:0] z; } exp_t;
  exp_t sb_q[$];
  logic [W-1:0] mdl_m = '0;
  logic [W-1:0] mdl_z = '0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare finished results against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) chk("R9 done without pending op", 1, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk("R9 m at done", int'(m_o), int'(e.m));
        chk("R9 z at done", int'(z_o), int'(e.z));
      end
    end
  end

  task automatic run_op(input int op, input logic [W-1:0] ai, bi, ci,
                        input bit poke, input string tag);
    logic [W-1:0] m0, z0, mn, zn;
    m0 = mdl_m; z0 = mdl_z; mn = m0; zn = z0;
    case (op)
      0: mn = ai * bi;
      1: zn = ci + m0;
      2: zn = ci - m0;
      3: begin mn = ai * bi; zn = z0 + mn; end
      4: begin mn = ai * bi; zn = z0 - mn; end
      5: mn = m0 * ai;
      default: ;
    endcase
    mdl_m = mn; mdl_z = zn;
    sb_q.push_back({mn, zn});
    @(negedge clk);
    opcode = 3'(op); a = ai; b = bi; c = ci; start = 1'b1;
    @(negedge clk);            // after start edge k
    start = 1'b0;
    chk({"R9 busy after start ", tag}, int'(busy), 1);
    chk({"R8 m hold k ", tag}, int'(m_o), int'(m0));
    for (int j = 1; j < LAT; j++) begin
      start = (poke && j == 2);
      @(negedge clk);
      chk({"R8 m hold ", tag}, int'(m_o), int'(m0));
      chk({"R9 busy held ", tag}, int'(busy), 1);
      if (poke && j == 3) chk("R10 busy after ignored start", int'(busy), 1);
    end
    start = 1'b0;
    @(negedge clk);            // after edge k+LAT
    chk({tag, " m update"}, int'(m_o), int'(mn));
    chk({"R8 z hold ", tag}, int'(z_o), int'(z0));
    chk({"R9 busy before sum ", tag}, int'(busy), 1);
    @(negedge clk);            // after edge k+LAT+1
    chk({tag, " z update"}, int'(z_o), int'(zn));
    chk({"R9 busy clear ", tag}, int'(busy), 0);
    chk({"R9 done pulse ", tag}, int'(done), 1);
    @(negedge clk);
    chk({"R9 done single ", tag}, int'(done), 0);
    if (poke) chk("R10 no extra op", int'(busy), 0);
  endtask

  task automatic reserved_op(input int op);
    @(negedge clk);
    opcode = 3'(op); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < LAT + 3; j++) begin
      chk("R11 reserved no busy", int'(busy), 0);
      chk("R11 reserved no done", int'(done), 0);
      @(negedge clk);
    end
    chk("R11 reserved m unchanged", int'(m_o), int'(mdl_m));
    chk("R11 reserved z unchanged", int'(z_o), int'(mdl_z));
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = '0; a = '0; b = '0; c = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset m", int'(m_o), 0);
    chk("R1 reset z", int'(z_o), 0);
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;

    run_op(0, 8'd3, 8'd5, 8'd0, 0, "R2");
    run_op(1, 8'd0, 8'd0, 8'd10, 0, "R3");
    run_op(2, 8'd0, 8'd0, 8'd4, 0, "R4 R12");
    run_op(3, 8'd2, 8'd7, 8'd0, 0, "R5 R12");
    run_op(4, 8'd3, 8'd3, 8'd0, 1, "R6 R10");
    run_op(5, 8'd4, 8'd0, 8'd0, 0, "R7");
    run_op(5, 8'd8, 8'd0, 8'd0, 0, "R7 R12 wrap");
    run_op(0, 8'hFD, 8'd6, 8'd0, 0, "R2 R12 signed");
    reserved_op(6);
    reserved_op(7);
    run_op(3, 8'd16, 8'd16, 8'd0, 0, "R5 R12 zero wrap");
    run_op(4, 8'hF0, 8'd2, 8'd0, 0, "R6 R12");

    // reset in the middle of an operation
    @(negedge clk);
    opcode = 3'd0; a = 8'd5; b = 8'd5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-op reset m", int'(m_o), 0);
    chk("R1 mid-op reset z", int'(z_o), 0);
    chk("R1 mid-op reset busy", int'(busy), 0);
    rst_n = 1'b1;
    mdl_m = '0; mdl_z = '0;
    repeat (LAT + 2) @(negedge clk);
    chk("R1 abandoned op no m update", int'(m_o), 0);

    run_op(1, 8'd0, 8'd0, 8'd1, 0, "R3 after reset");
    chk("R9 scoreboard drained", sb_q.size(), 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R9 watchdog expired actual=hung expected=complete");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule